// File: doc/BRIEF.md
# Ring Oscillator Signature Readout

This block derives an 8-bit device fingerprint from sixteen free-running ring oscillators. Each oscillator output arrives as a clock input and drives its own 15-bit edge counter in that oscillator's domain. The oscillators are grouped into eight fixed pairs. A controller in the system clock domain runs a measurement window of programmable length and then waits a fixed settle time. It then compares the two counts of every pair and latches one signature bit per pair.

The counts cross into the system domain as Gray codes through two-flop synchronizers. The controller therefore reads a coherent value even while the counters keep running. The latched signature is presented both as a plain vector and as an active-low LED drive. Two mode inputs change the behaviour. One limits counting to the measurement window. The other turns the ordering test into an equality test, which confirms that paired oscillators really differ.

Top module: `ropuf_readout`

## Requirements
- R1: Signature bit k compares oscillator input 2k (side A) with oscillator input 2k+1 (side B). In normal mode the bit is 1 exactly when the A count is strictly greater than the B count.
- R2: When the two counts of a pair are equal, the normal-mode bit is 0.
- R3: Each counter is 15 bits wide and counts rising edges of its own oscillator input while enabled. The system reset clears it to zero. An oscillator that stops after reset keeps a count near zero, so it loses against a running partner.
- R4: After the clock edge that accepts `start`, `done` rises in the cycle following edge number max(`win_cycles`,1) + 16. Here 16 is the default settle length, and a window value of 0 behaves like 1.
- R5: `done` is high for exactly one system cycle. `sig` changes only on the edge that raises `done` and otherwise holds its value.
- R6: `led_n` is always the bitwise inverse of `sig`, so a 0 bit lights its LED. Reset gives `sig` = 0, `led_n` = all ones and `done` = 0.
- R7: With `gate_mode` = 0 the counters count continuously from reset. With `gate_mode` = 1 they count only while a measurement window is open, so edges seen between measurements have no effect on the result.
- R8: With `eq_debug` = 1, each latched bit is 1 exactly when the two counts of its pair are equal.
- R9: A `start` pulse that arrives while a measurement is in progress is ignored. Completion timing is unchanged, and no extra measurement follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, also clears all oscillator counters |
| osc_in | input | 16 | Oscillator clocks; bit 2k is side A and bit 2k+1 is side B of pair k |
| start | input | 1 | Begin a measurement (accepted only when idle) |
| win_cycles | input | 16 | Measurement window length in system cycles |
| gate_mode | input | 1 | 0: counters always enabled; 1: enabled only during the window |
| eq_debug | input | 1 | 1: bits report count equality instead of A greater than B |
| sig | output | 8 | Latched signature |
| led_n | output | 8 | Active-low LED drive, inverse of `sig` |
| done | output | 1 | One-cycle pulse when a new signature is latched |

## Verification
Counting from the system edge that accepts `start`, all results appear together: the `done` pulse, the new `sig` and the new `led_n` are due one register after edge number window+16. The bench counts system edges from the accepting edge and samples every output on the falling edge. It requires `done` at exactly that count and low on the next falling edge. It reads the signature and LED values in the cycle in which `done` is seen. Oscillator periods are spread widely enough that the skew from synchronizing each counter's enable and snapshot, a few edges at most, cannot flip an expected bit.

// File: rtl/ropuf_pkg.sv
package ropuf_pkg;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_RUN    = 2'd1,
    S_SETTLE = 2'd2
  } meas_state_t;

endpackage

// File: rtl/ropuf_osc_counter.sv
module ropuf_osc_counter #(
  parameter int CNT_W = 15
) (
  input  logic             osc_clk,
  input  logic             clr_req,
  input  logic             en_req,
  output logic [CNT_W-1:0] gray_out
);

  // Request synchronizers in the oscillator domain, powered up in clear.
  logic [1:0]       clr_sync = 2'b11;
  logic [1:0]       en_sync  = 2'b00;
  logic             clr_s;
  logic             en_s;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gray_q;

  always_ff @(posedge osc_clk) begin
    clr_sync <= {clr_sync[0], clr_req};
    en_sync  <= {en_sync[0], en_req};
  end

  assign clr_s = clr_sync[1];
  assign en_s  = en_sync[1];

  always_ff @(posedge osc_clk) begin
    if (clr_s) begin
      cnt_q  <= '0;
      gray_q <= '0;
    end else begin
      if (en_s) cnt_q <= cnt_q + 1'b1;
      gray_q <= cnt_q ^ (cnt_q >> 1);
    end
  end

  assign gray_out = gray_q;

  // R3: a clear request empties the counter
  p_clear_zero_r3: assert property (@(posedge osc_clk) clr_s |=> cnt_q == '0);
  // R7: with the enable low the count does not move
  p_frozen_when_off_r7: assert property (@(posedge osc_clk) disable iff (clr_s)
    !en_s |=> $stable(cnt_q));

endmodule

// File: rtl/ropuf_gray_sync.sv
module ropuf_gray_sync #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);

  logic [CNT_W-1:0] s1_q;
  logic [CNT_W-1:0] s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      bin_out[i] = ^(s2_q >> i);
    end
  end

endmodule

// File: rtl/ropuf_ctrl.sv
module ropuf_ctrl
  import ropuf_pkg::*;
#(
  parameter int WIN_W      = 16,
  parameter int SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIN_W-1:0] win_cycles,
  input  logic             gate_mode,
  output logic             cnt_en,
  output logic             cap
);

  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  meas_state_t      state_q, state_n;
  logic [WIN_W-1:0] win_cnt_q;
  logic [SET_W-1:0] set_cnt_q;
  logic             en_q;
  logic             win_last;
  logic             set_last;

  assign win_last = ({1'b0, win_cnt_q} + {{WIN_W{1'b0}}, 1'b1}) >= {1'b0, win_cycles};
  assign set_last = set_cnt_q == SET_W'(SETTLE_CYC - 1);

  always_comb begin
    state_n = state_q;
    case (state_q)
      S_IDLE:   if (start)    state_n = S_RUN;
      S_RUN:    if (win_last) state_n = S_SETTLE;
      S_SETTLE: if (set_last) state_n = S_IDLE;
      default:                state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      win_cnt_q <= '0;
      set_cnt_q <= '0;
      en_q      <= 1'b0;
    end else begin
      state_q   <= state_n;
      win_cnt_q <= (state_q == S_RUN) ? win_cnt_q + 1'b1 : '0;
      set_cnt_q <= (state_q == S_SETTLE) ? set_cnt_q + 1'b1 : '0;
      en_q      <= ~gate_mode | (state_n == S_RUN);
    end
  end

  assign cnt_en = en_q;
  assign cap    = (state_q == S_SETTLE) && set_last;

  // R9: a window in progress only ever continues from the window itself
  p_run_continues_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RUN && win_cnt_q != '0) |-> $past(state_q) == S_RUN);
  // R4: the settle phase runs without interruption
  p_settle_continues_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SETTLE && set_cnt_q != '0) |-> $past(state_q) == S_SETTLE);

endmodule

// File: rtl/ropuf_readout.sv
module ropuf_readout #(
  parameter int N_PAIRS    = 8,
  parameter int CNT_W      = 15,
  parameter int WIN_W      = 16,
  parameter int SETTLE_CYC = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*N_PAIRS-1:0]   osc_in,
  input  logic                   start,
  input  logic [WIN_W-1:0]       win_cycles,
  input  logic                   gate_mode,
  input  logic                   eq_debug,
  output logic [N_PAIRS-1:0]     sig,
  output logic [N_PAIRS-1:0]     led_n,
  output logic                   done
);

  localparam int N_OSC = 2 * N_PAIRS;

  logic                 cnt_en;
  logic                 cap;
  logic [CNT_W-1:0]     gray_w [N_OSC];
  logic [CNT_W-1:0]     bin_w  [N_OSC];
  logic [N_PAIRS-1:0]   res;
  logic [N_PAIRS-1:0]   sig_q;
  logic [N_PAIRS-1:0]   led_q;
  logic                 done_q;

  ropuf_ctrl #(.WIN_W(WIN_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .win_cycles (win_cycles),
    .gate_mode  (gate_mode),
    .cnt_en     (cnt_en),
    .cap        (cap)
  );

  for (genvar o = 0; o < N_OSC; o++) begin : g_osc
    ropuf_osc_counter #(.CNT_W(CNT_W)) u_cnt (
      .osc_clk  (osc_in[o]),
      .clr_req  (rst),
      .en_req   (cnt_en),
      .gray_out (gray_w[o])
    );
    ropuf_gray_sync #(.CNT_W(CNT_W)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .gray_in (gray_w[o]),
      .bin_out (bin_w[o])
    );
  end

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_cmp
    assign res[k] = eq_debug ? (bin_w[2*k] == bin_w[2*k+1])
                             : (bin_w[2*k] >  bin_w[2*k+1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q  <= '0;
      led_q  <= '1;
      done_q <= 1'b0;
    end else begin
      done_q <= cap;
      if (cap) begin
        sig_q <= res;
        led_q <= ~res;
      end
    end
  end

  assign sig   = sig_q;
  assign led_n = led_q;
  assign done  = done_q;

  // R5: completion is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);
  // R5: the signature holds between completions
  p_sig_hold_r5: assert property (@(posedge clk) disable iff (rst) !done_q |-> $stable(sig_q));
  // R6: LED drive is the inverse of the signature
  p_led_polarity_r6: assert property (@(posedge clk) disable iff (rst) led_q == ~sig_q);

endmodule

// File: tb/ropuf_readout_bench.sv
`timescale 1ns/1ps
module ropuf_readout_bench;

  localparam int SETTLE = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] win_cycles = 16'd1;
  logic        gate_mode = 1'b0;
  logic        eq_debug = 1'b0;
  logic [7:0]  sig;
  logic [7:0]  led_n;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;

  // oscillator models
  logic c0a = 0, c0b = 0, c1a = 0, c1b = 0, c2a = 0, c2b = 0, c3 = 0;
  logic c4a = 0, c4b = 0, c5a = 0, c5b = 0, c6 = 0, c7a = 0, c7b = 0;
  logic run4b = 1, run5a = 1, hold6 = 0;
  logic [15:0] osc;

  always #5 clk = ~clk;
  always #3.0 c0a = ~c0a;
  always #4.0 c0b = ~c0b;
  always #4.0 c1a = ~c1a;
  always #3.0 c1b = ~c1b;
  always #5.0 c2a = ~c2a;
  always #5.5 c2b = ~c2b;
  always #4.5 c3  = ~c3;
  always #3.5 c4a = ~c4a;
  always #3.5 if (run4b) c4b = ~c4b;
  always #3.5 if (run5a) c5a = ~c5a;
  always #3.5 c5b = ~c5b;
  always #5.0 c6  = ~c6;
  always #6.5 c7a = ~c7a;
  always #6.0 c7b = ~c7b;

  assign osc = {c7b, c7a, c6 & ~hold6, c6, c5b, c5a, c4b, c4a,
                c3, c3, c2b, c2a, c1b, c1a, c0b, c0a};

  ropuf_readout u_ropuf_readout (
    .clk(clk), .rst(rst), .osc_in(osc), .start(start), .win_cycles(win_cycles),
    .gate_mode(gate_mode), .eq_debug(eq_debug), .sig(sig), .led_n(led_n), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit gm);
    gate_mode = gm;
    run4b = 1; run5a = 1; hold6 = 0;
    rst = 1;
    repeat (20) @(negedge clk);
    rst = 0;
    run4b = 0; run5a = 0;
  endtask

  // one measurement; checks latency, pulse width, signature and LEDs
  task automatic measure(input int w, input bit poke, input logic [7:0] exp_sig, input string req);
    int lat = 0;
    int exp_lat = ((w < 1) ? 1 : w) + SETTLE;
    win_cycles = 16'(w);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    forever begin
      @(negedge clk);
      lat++;
      start = (poke && lat == 10);
      if (done || lat > 5000) break;
    end
    start = 0;
    check(lat == exp_lat, "R4 done latency", lat, exp_lat);
    check(sig == exp_sig, req, sig, exp_sig);
    check(led_n == ~exp_sig, "R6 led polarity", led_n, ~exp_sig);
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    gate_mode = 0;
    rst = 1;
    repeat (20) @(negedge clk);
    check(sig == 8'h00, "R6 reset sig", sig, 0);
    check(led_n == 8'hFF, "R6 reset led_n", led_n, 8'hFF);
    check(done == 1'b0, "R6 reset done", done, 0);
    rst = 0;
    run4b = 0; run5a = 0;
  endtask

  task automatic t_signature();
    // R1 R2 R3: pairs 0,2,4 win; pair 3,6 equal; pair 5 stopped A
    measure(200, 0, 8'h15, "R1 R2 R3 signature");
  endtask

  task automatic t_timing();
    measure(1, 0, 8'h15, "R4 window 1");
    measure(0, 0, 8'h15, "R4 window 0");
    measure(40, 0, 8'h15, "R4 window 40");
  endtask

  task automatic t_hold();
    bit moved = 0;
    bit pulsed = 0;
    logic [7:0] snap = sig;
    repeat (100) begin
      @(negedge clk);
      if (sig != snap) moved = 1;
      if (done) pulsed = 1;
    end
    check(!moved, "R5 signature holds", sig, snap);
    check(!pulsed, "R5 no spontaneous done", pulsed, 0);
  endtask

  task automatic t_busy();
    bit pulsed = 0;
    measure(60, 1, 8'h15, "R9 signature with extra start");
    repeat (150) begin
      @(negedge clk);
      if (done) pulsed = 1;
    end
    check(!pulsed, "R9 extra start ignored", pulsed, 0);
  endtask

  task automatic t_debug();
    eq_debug = 1;
    measure(200, 0, 8'h48, "R8 equality mode");
    eq_debug = 0;
  endtask

  task automatic t_gated(input bit gm, input logic [7:0] exp_sig, input string req);
    do_reset(gm);
    @(negedge c6) hold6 = 1;
    repeat (400) @(negedge clk);
    @(negedge c6) hold6 = 0;
    @(negedge clk);
    measure(200, 0, exp_sig, req);
  endtask

  initial begin
    t_reset();
    t_signature();
    t_timing();
    t_hold();
    t_busy();
    t_debug();
    t_gated(1, 8'h15, "R7 windowed counting ignores idle edges");
    t_gated(0, 8'h55, "R7 continuous counting sees idle edges");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule